// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Port

This block holds a calendar time (seconds, minutes, hours, day of week, day of month, month and a one-byte year) in plain binary with a 24-hour day. It also holds two control registers. Software reaches all of them through two byte-wide ports that share one access strobe. A write to the index port picks a register. Later accesses to the data port then read or write that register. A once-per-second enable input advances the time, including the carry from day into month and from month into year.

A periodic interrupt comes from a small two-state machine. `PT_STOP` moves to `PT_RUN` on a *start*, which is a valid control-B write with the enable bit set. `PT_RUN` returns to `PT_STOP` on a *stop*, which is a valid control-B write with the enable bit clear. In `PT_RUN` a down-counter expires every `PERIOD_CYCLES` clocks. Each expiry gives a one-cycle pulse and reloads the counter. The status register carries an update-in-progress flag that flips on every read. A one-cycle error pulse reports accesses that the block does not support.

Top module: `calendar_reg_port`

## Requirements
- R1: A write cycle on the index port (`acc_port`=0) stores the byte as the current index. `acc_rdata` shows the stored index while `acc_port`=0. While `acc_port`=1 it shows the register that the index selects. The index resets to 0.
- R2: Status index 10 reads as {flag, 7'h26}. The flag resets to 1 and inverts after every data-port read at index 10.
- R3: Control index 11 always reads 8'h46. Index 12 and the alarm indices 1, 3 and 5 read 0. Writes to the alarm indices have no effect and raise no error.
- R4: A control-B write is valid only when (data & 8'hB7) == 8'h06. A valid write with bit 6 set moves `PT_STOP` to `PT_RUN` and leaves a running timer untouched. A valid write with bit 6 clear returns to `PT_STOP` and drops any expiry in that cycle. An invalid write changes nothing.
- R5: `err_pulse` is high for one cycle after any of these data-port accesses: an index above 13 (which also reads 0), a status write other than 8'h26, an invalid control-B write, any write to index 12 or 13, or a read of index 13.
- R6: `irq_pulse` first goes high on the `PERIOD_CYCLES`-th rising edge after the edge that takes the start write. After that it goes high every `PERIOD_CYCLES` edges, for one cycle each time. It resets low.
- R7: The time fields sit at index 0 (sec), 2 (min), 4 (hour), 6 (day of week), 7 (day of month), 8 (month) and 9 (year). A data write stores the raw byte. Reset gives 0, 0, 0, 1, 1, 1, 0.
- R8: On `sec_tick` the seconds advance. Any field at or above its last value (59, 59, 23, month length, 12) wraps and carries to the next field. Day of week cycles 1 to 7. Months 4, 6, 9 and 11 have 30 days, February has 29 when year mod 4 is 0 and 28 otherwise, and every other month has 31. The year wraps from 255 to 0.
- R9: A `sec_tick` in a cycle that holds a data-port write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, combinational |
| sec_tick | input | 1 | Once-per-second advance enable |
| irq_pulse | output | 1 | Periodic interrupt pulse |
| err_pulse | output | 1 | Unsupported-access pulse |

## Verification
The bench drives the calendar across a leap February, a non-leap February, a 30-day month and a year wrap from 255. A design with a wrong month table or leap test would land on the wrong day or month, and a wrong carry chain would leave a field stuck or over-advanced. It repeats the enable write while the timer runs: a design that restarts there would shift the next pulse by a whole period. It also checks that a stop write silences the pulses and that an invalid write never starts them. The status flag is read back to back, and a tick is placed on the same cycle as a time write. An inverted-flag design, or one that lets the tick win, would return values that differ from the reference model.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    localparam int BYTE_W = 8;
    localparam int NFIELD = 7;

    // time field positions inside the write-select vector
    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DOW = 3;
    localparam int F_DOM = 4;
    localparam int F_MON = 5;
    localparam int F_YR  = 6;

    // register index map seen by software
    localparam logic [BYTE_W-1:0] IX_SEC   = 8'd0;
    localparam logic [BYTE_W-1:0] IX_MIN   = 8'd2;
    localparam logic [BYTE_W-1:0] IX_HR    = 8'd4;
    localparam logic [BYTE_W-1:0] IX_DOW   = 8'd6;
    localparam logic [BYTE_W-1:0] IX_DOM   = 8'd7;
    localparam logic [BYTE_W-1:0] IX_MON   = 8'd8;
    localparam logic [BYTE_W-1:0] IX_YR    = 8'd9;
    localparam logic [BYTE_W-1:0] IX_STAT  = 8'd10;
    localparam logic [BYTE_W-1:0] IX_CTLB  = 8'd11;
    localparam logic [BYTE_W-1:0] IX_FLAGS = 8'd12;
    localparam logic [BYTE_W-1:0] IX_CTLD  = 8'd13;
    localparam logic [BYTE_W-1:0] IX_LAST  = 8'd13;

    localparam logic [BYTE_W-2:0] STAT_FIXED = 7'h26;
    localparam logic [BYTE_W-1:0] CTLB_VIEW  = 8'h46;
    localparam logic [BYTE_W-1:0] CTLB_FREE  = 8'h48;
    localparam logic [BYTE_W-1:0] CTLB_NEED  = 8'h06;
    localparam int               CTLB_EN_BIT = 6;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] dom;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] yr;
    } cal_time_t;

    localparam cal_time_t TIME_RST = '{sec: 8'd0, min: 8'd0, hr: 8'd0,
                                       dow: 8'd1, dom: 8'd1, mon: 8'd1,
                                       yr: 8'd0};

    typedef enum logic {PT_STOP, PT_RUN} pt_state_e;

    function automatic logic [BYTE_W-1:0] month_len(input logic [BYTE_W-1:0] mon,
                                                    input logic [BYTE_W-1:0] yr);
        logic [BYTE_W-1:0] len;
        if (mon == 8'd2)
            len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
        else if (mon == 8'd4 || mon == 8'd6 || mon == 8'd9 || mon == 8'd11)
            len = 8'd30;
        else
            len = 8'd31;
        return len;
    endfunction

endpackage

// File: rtl/cal_timekeep.sv
`timescale 1ns/1ps
module cal_timekeep
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NFIELD-1:0]     wr_sel,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  tick_go,
    output cal_time_t             now
);

    cal_time_t cur_q;
    cal_time_t nxt;
    logic [BYTE_W-1:0] dim;

    always_comb begin
        dim = month_len(cur_q.mon, cur_q.yr);
        nxt = cur_q;
        if (|wr_sel) begin
            if (wr_sel[F_SEC]) nxt.sec = wdata;
            if (wr_sel[F_MIN]) nxt.min = wdata;
            if (wr_sel[F_HR])  nxt.hr  = wdata;
            if (wr_sel[F_DOW]) nxt.dow = wdata;
            if (wr_sel[F_DOM]) nxt.dom = wdata;
            if (wr_sel[F_MON]) nxt.mon = wdata;
            if (wr_sel[F_YR])  nxt.yr  = wdata;
        end else if (tick_go) begin
            if (cur_q.sec < 8'd59) begin
                nxt.sec = cur_q.sec + 8'd1;
            end else begin
                nxt.sec = 8'd0;
                if (cur_q.min < 8'd59) begin
                    nxt.min = cur_q.min + 8'd1;
                end else begin
                    nxt.min = 8'd0;
                    if (cur_q.hr < 8'd23) begin
                        nxt.hr = cur_q.hr + 8'd1;
                    end else begin
                        nxt.hr  = 8'd0;
                        nxt.dow = (cur_q.dow < 8'd7) ? cur_q.dow + 8'd1 : 8'd1;
                        if (cur_q.dom < dim) begin
                            nxt.dom = cur_q.dom + 8'd1;
                        end else begin
                            nxt.dom = 8'd1;
                            if (cur_q.mon < 8'd12) begin
                                nxt.mon = cur_q.mon + 8'd1;
                            end else begin
                                nxt.mon = 8'd1;
                                nxt.yr  = cur_q.yr + 8'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= TIME_RST;
        else        cur_q <= nxt;
    end

    assign now = cur_q;

endmodule

// File: rtl/cal_periodic.sv
`timescale 1ns/1ps
module cal_periodic
    import cal_pkg::*;
#(
    parameter int PERIOD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic running,
    output logic irq
);

    localparam int CW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD_CYCLES - 1);

    pt_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           irq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PT_STOP: if (start) state_d = PT_RUN;
            PT_RUN:  if (stop)  state_d = PT_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PT_STOP;
        else        state_q <= state_d;
    end

    // counter and pulse output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                PT_STOP: begin
                    if (start) cnt_q <= RELOAD;
                end
                PT_RUN: begin
                    if (!stop) begin
                        if (cnt_q == '0) begin
                            irq_q <= 1'b1;
                            cnt_q <= RELOAD;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign running = (state_q == PT_RUN);
    assign irq     = irq_q;

endmodule

// File: rtl/cal_access.sv
`timescale 1ns/1ps
module cal_access
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_en,
    input  logic                  acc_wr,
    input  logic                  acc_port,
    input  logic [BYTE_W-1:0]     acc_wdata,
    input  logic                  sec_tick,
    input  cal_time_t             now,
    output logic [BYTE_W-1:0]     rdata,
    output logic [BYTE_W-1:0]     idx_q,
    output logic                  uip_q,
    output logic [NFIELD-1:0]     wr_sel,
    output logic                  pt_start,
    output logic                  pt_stop,
    output logic                  tick_go,
    output logic                  err_q
);

    logic data_acc, dwr, drd, idx_wr, in_range, ctlb_ok, bad;

    assign data_acc = acc_en & acc_port;
    assign dwr      = data_acc & acc_wr;
    assign drd      = data_acc & ~acc_wr;
    assign idx_wr   = acc_en & ~acc_port & acc_wr;
    assign in_range = (idx_q <= IX_LAST);
    assign ctlb_ok  = ((acc_wdata & ~CTLB_FREE) == CTLB_NEED);
    assign tick_go  = sec_tick & ~dwr;

    always_comb begin
        wr_sel = '0;
        if (dwr) begin
            case (idx_q)
                IX_SEC:  wr_sel[F_SEC] = 1'b1;
                IX_MIN:  wr_sel[F_MIN] = 1'b1;
                IX_HR:   wr_sel[F_HR]  = 1'b1;
                IX_DOW:  wr_sel[F_DOW] = 1'b1;
                IX_DOM:  wr_sel[F_DOM] = 1'b1;
                IX_MON:  wr_sel[F_MON] = 1'b1;
                IX_YR:   wr_sel[F_YR]  = 1'b1;
                default: wr_sel = '0;
            endcase
        end
    end

    assign pt_start = dwr & (idx_q == IX_CTLB) & ctlb_ok &  acc_wdata[CTLB_EN_BIT];
    assign pt_stop  = dwr & (idx_q == IX_CTLB) & ctlb_ok & ~acc_wdata[CTLB_EN_BIT];

    always_comb begin
        bad = 1'b0;
        if (data_acc && !in_range) bad = 1'b1;
        if (dwr && idx_q == IX_STAT && acc_wdata != {1'b0, STAT_FIXED}) bad = 1'b1;
        if (dwr && idx_q == IX_CTLB && !ctlb_ok) bad = 1'b1;
        if (dwr && (idx_q == IX_FLAGS || idx_q == IX_CTLD)) bad = 1'b1;
        if (drd && idx_q == IX_CTLD) bad = 1'b1;
    end

    always_comb begin
        if (!acc_port) begin
            rdata = idx_q;
        end else begin
            case (idx_q)
                IX_SEC:  rdata = now.sec;
                IX_MIN:  rdata = now.min;
                IX_HR:   rdata = now.hr;
                IX_DOW:  rdata = now.dow;
                IX_DOM:  rdata = now.dom;
                IX_MON:  rdata = now.mon;
                IX_YR:   rdata = now.yr;
                IX_STAT: rdata = {uip_q, STAT_FIXED};
                IX_CTLB: rdata = CTLB_VIEW;
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            uip_q <= 1'b1;
            err_q <= 1'b0;
        end else begin
            if (idx_wr) idx_q <= acc_wdata;
            if (drd && idx_q == IX_STAT) uip_q <= ~uip_q;
            err_q <= bad;
        end
    end

endmodule

// File: rtl/calendar_reg_port.sv
`timescale 1ns/1ps
module calendar_reg_port
    import cal_pkg::*;
#(
    parameter int PERIOD_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       acc_wr,
    input  logic       acc_port,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    input  logic       sec_tick,
    output logic       irq_pulse,
    output logic       err_pulse
);

    cal_time_t          now;
    logic [BYTE_W-1:0]  idx_q;
    logic               uip_q;
    logic [NFIELD-1:0]  wr_sel;
    logic               pt_start, pt_stop, pt_run, tick_go;
    logic [BYTE_W-1:0]  sec_q;

    cal_access u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_port  (acc_port),
        .acc_wdata (acc_wdata),
        .sec_tick  (sec_tick),
        .now       (now),
        .rdata     (acc_rdata),
        .idx_q     (idx_q),
        .uip_q     (uip_q),
        .wr_sel    (wr_sel),
        .pt_start  (pt_start),
        .pt_stop   (pt_stop),
        .tick_go   (tick_go),
        .err_q     (err_pulse)
    );

    cal_timekeep u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wdata   (acc_wdata),
        .tick_go (tick_go),
        .now     (now)
    );

    cal_periodic #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_periodic (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pt_start),
        .stop    (pt_stop),
        .running (pt_run),
        .irq     (irq_pulse)
    );

    assign sec_q = now.sec;

endmodule

// File: rtl/calendar_reg_port_chk.sv
`timescale 1ns/1ps
module calendar_reg_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_en,
    input logic       acc_wr,
    input logic       acc_port,
    input logic [7:0] acc_rdata,
    input logic       irq_pulse,
    input logic       err_pulse,
    input logic [7:0] idx_q,
    input logic       uip_q,
    input logic [7:0] sec_q,
    input logic       tick_go,
    input logic       pt_run
);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_quiet_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pt_run |=> !irq_pulse);

    assert_err_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(acc_en && acc_port));

    assert_oor_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_port && idx_q > 8'd13) |-> (acc_rdata == 8'd0));

    assert_flag_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_port && !acc_wr && idx_q == 8'd10) |=> (uip_q != $past(uip_q)));

    assert_sec_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_go && sec_q < 8'd59) |=> (sec_q == $past(sec_q) + 8'd1));

endmodule

bind calendar_reg_port calendar_reg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_port  (acc_port),
    .acc_rdata (acc_rdata),
    .irq_pulse (irq_pulse),
    .err_pulse (err_pulse),
    .idx_q     (idx_q),
    .uip_q     (uip_q),
    .sec_q     (sec_q),
    .tick_go   (tick_go),
    .pt_run    (pt_run)
);

// File: tb/calendar_reg_port_tb.sv
`timescale 1ns/1ps
module calendar_reg_port_tb;

    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0, acc_port = 1'b0, sec_tick = 1'b0;
    logic [7:0] acc_wdata = 8'd0;
    wire  [7:0] acc_rdata;
    wire        irq_pulse, err_pulse;

    always #2.5 clk = ~clk;

    calendar_reg_port #(.PERIOD_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .sec_tick(sec_tick), .irq_pulse(irq_pulse), .err_pulse(err_pulse));

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit live = 0;

    // behavioural reference state
    int m_sec = 0, m_min = 0, m_hr = 0, m_dow = 1, m_dom = 1, m_mon = 1, m_yr = 0;
    int m_idx = 0, m_left = 0;
    bit m_uip = 1, m_run = 0, m_irq = 0, m_err = 0;
    bit q, e, dwr, c;

    function automatic int mdays(int mo, int y);
        int tbl[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo >= 1 && mo <= 12) return tbl[mo-1];
        return 31;
    endfunction

    function automatic int model_rd();
        if (!acc_port) return m_idx;
        case (m_idx)
            0: return m_sec;   2: return m_min;  4: return m_hr;
            6: return m_dow;   7: return m_dom;  8: return m_mon;
            9: return m_yr;
            10: return (int'(m_uip) << 7) | 'h26;
            11: return 'h46;
            default: return 0;
        endcase
    endfunction

    task advance();
        m_sec = m_sec + 1; c = (m_sec >= 60); if (c) m_sec = 0;
        if (c) begin m_min = m_min + 1; c = (m_min >= 60); if (c) m_min = 0; end
        if (c) begin m_hr = m_hr + 1; c = (m_hr >= 24); if (c) m_hr = 0; end
        if (c) begin
            m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
            m_dom = m_dom + 1; c = (m_dom > mdays(m_mon, m_yr)); if (c) m_dom = 1;
        end
        if (c) begin m_mon = m_mon + 1; c = (m_mon > 12); if (c) m_mon = 1; end
        if (c) m_yr = (m_yr + 1) % 256;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0;
            m_idx = 0; m_uip = 1; m_run = 0; m_left = 0; m_irq = 0; m_err = 0;
        end else begin
            dwr = acc_en && acc_port && acc_wr;
            q = 0; e = 0;
            if (m_run) begin
                if (m_left == 0) begin q = 1; m_left = P - 1; end
                else m_left = m_left - 1;
            end
            if (acc_en && !acc_port && acc_wr) m_idx = acc_wdata;
            else if (acc_en && acc_port) begin
                if (m_idx > 13) e = 1;
                else if (acc_wr) begin
                    case (m_idx)
                        0: m_sec = acc_wdata;  2: m_min = acc_wdata;
                        4: m_hr = acc_wdata;   6: m_dow = acc_wdata;
                        7: m_dom = acc_wdata;  8: m_mon = acc_wdata;
                        9: m_yr = acc_wdata;
                        10: if (acc_wdata != 8'h26) e = 1;
                        11: begin
                            if ((acc_wdata & 8'hB7) != 8'h06) e = 1;
                            else if (acc_wdata[6]) begin
                                if (!m_run) begin m_run = 1; m_left = P - 1; end
                            end else begin m_run = 0; q = 0; end
                        end
                        12, 13: e = 1;
                        default: ;
                    endcase
                end else begin
                    if (m_idx == 10) m_uip = ~m_uip;
                    if (m_idx == 13) e = 1;
                end
            end
            if (sec_tick && !dwr) advance();
            m_irq = q; m_err = e;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (live) begin
            #1;
            chk(acc_rdata == 8'(model_rd()), "R1", acc_rdata, model_rd());
            chk(irq_pulse == m_irq, "R6", irq_pulse, m_irq);
            chk(err_pulse == m_err, "R5", err_pulse, m_err);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cyc(bit en, bit wr, bit port, int d, bit tk);
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_port = port; acc_wdata = 8'(d); sec_tick = tk;
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

    task automatic wr_reg(int ix, int d, bit tk = 0);
        cyc(1, 1, 0, ix, 0);
        cyc(1, 1, 1, d, tk);
    endtask

    task automatic rd_reg(int ix, int exp, string tag);
        cyc(1, 1, 0, ix, 0);
        cyc(1, 0, 1, 0, 0);
        #1 chk(acc_rdata == 8'(exp), tag, acc_rdata, exp);
    endtask

    task automatic expect_err(bit exp, string tag);
        idle();
        #1 chk(err_pulse == exp, tag, err_pulse, exp);
    endtask

    task automatic tick(); cyc(0, 0, 0, 0, 1); endtask

    task automatic set_time(int s, int mi, int h, int dw, int dm, int mo, int y);
        wr_reg(0, s); wr_reg(2, mi); wr_reg(4, h); wr_reg(6, dw);
        wr_reg(7, dm); wr_reg(8, mo); wr_reg(9, y);
    endtask

    task automatic chk_time(int s, int mi, int h, int dw, int dm, int mo, int y, string tag);
        rd_reg(0, s, tag); rd_reg(2, mi, tag); rd_reg(4, h, tag); rd_reg(6, dw, tag);
        rd_reg(7, dm, tag); rd_reg(8, mo, tag); rd_reg(9, y, tag);
    endtask

    initial begin
        int k;
        bit seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        #1;
        chk(irq_pulse == 1'b0, "R6 reset", irq_pulse, 0);
        chk(err_pulse == 1'b0, "R5 reset", err_pulse, 0);
        chk(acc_rdata == 8'd0, "R1 reset index", acc_rdata, 0);
        chk_time(0, 0, 0, 1, 1, 1, 0, "R7 reset");

        // R1: index port readback
        cyc(1, 1, 0, 9, 0);
        cyc(1, 0, 0, 0, 0);
        #1 chk(acc_rdata == 8'd9, "R1", acc_rdata, 9);

        // R2: flag toggles per read
        rd_reg(10, 'hA6, "R2");
        rd_reg(10, 'h26, "R2");
        rd_reg(10, 'hA6, "R2");

        // R3: fixed and zero registers, alarm writes ignored
        rd_reg(11, 'h46, "R3");
        rd_reg(12, 0, "R3");
        rd_reg(1, 0, "R3"); rd_reg(3, 0, "R3"); rd_reg(5, 0, "R3");
        wr_reg(1, 'h55); expect_err(0, "R3");
        rd_reg(1, 0, "R3"); rd_reg(0, 0, "R3");

        // R5: unsupported accesses
        rd_reg(14, 0, "R5"); expect_err(1, "R5");
        wr_reg(13, 0); expect_err(1, "R5");
        wr_reg(12, 0); expect_err(1, "R5");
        wr_reg(10, 'h20); expect_err(1, "R5");
        wr_reg(10, 'h26); expect_err(0, "R5");
        rd_reg(13, 0, "R5"); expect_err(1, "R5");
        rd_reg(200, 0, "R5"); expect_err(1, "R5");

        // R4: invalid control write starts nothing
        wr_reg(11, 'hC6); expect_err(1, "R4");
        seen = 0;
        repeat (2*P) begin idle(); #1 if (irq_pulse) seen = 1; end
        chk(!seen, "R4 invalid no start", seen, 0);

        // R6: start and period
        wr_reg(11, 'h46);
        k = 0;
        do begin idle(); #1 k++; end while (!irq_pulse && k < 4*P);
        chk(k == P + 1, "R6 first pulse", k, P + 1);
        k = 0;
        do begin idle(); #1 k++; end while (!irq_pulse && k < 4*P);
        chk(k == P, "R6 period", k, P);

        // R4: re-enable while running does not restart
        wr_reg(11, 'h4E);
        k = 0;
        do begin idle(); #1 k++; end while (!irq_pulse && k < 4*P);
        chk(k == P - 2, "R4 no restart", k, P - 2);

        // R4: stop
        wr_reg(11, 'h06);
        seen = 0;
        repeat (3*P) begin idle(); #1 if (irq_pulse) seen = 1; end
        chk(!seen, "R4 stopped", seen, 0);

        // R8: leap February
        set_time(59, 59, 23, 7, 28, 2, 4); tick();
        chk_time(0, 0, 0, 1, 29, 2, 4, "R8 leap");
        set_time(59, 59, 23, 1, 29, 2, 4); tick();
        chk_time(0, 0, 0, 2, 1, 3, 4, "R8 leap end");
        set_time(59, 59, 23, 3, 28, 2, 5); tick();
        chk_time(0, 0, 0, 4, 1, 3, 5, "R8 plain Feb");
        set_time(59, 59, 23, 5, 30, 4, 9); tick();
        chk_time(0, 0, 0, 6, 1, 5, 9, "R8 30-day");
        set_time(59, 59, 23, 6, 31, 12, 255); tick();
        chk_time(0, 0, 0, 7, 1, 1, 0, "R8 year wrap");
        set_time(30, 59, 10, 2, 15, 7, 20); tick();
        chk_time(31, 59, 10, 2, 15, 7, 20, "R8 simple");

        // R7 / R9: write wins over a coinciding tick
        wr_reg(0, 10, 1);
        rd_reg(0, 10, "R9");
        tick();
        rd_reg(0, 11, "R9");
        wr_reg(9, 77); rd_reg(9, 77, "R7");

        repeat (3) idle();
        live = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule